// File: doc/BRIEF.md
# Serial Link Mode Sensor

This block listens to a serial receive line and works out, from the first byte that arrives after it is armed, whether the host wants an asynchronous UART session or a clocked I/O-interface session. The host chooses the session by the byte it sends first. For UART it sends 0x86, framed as UART, at the intended baud rate. For the clocked interface it sends 0x30 at one sixteenth of the intended rate. The block times the gaps between the first four transitions of that byte and compares the first gap with the last one. That comparison tells the two patterns apart whatever the baud rate is.

The line passes through a two-flop synchronizer. The block then times the gaps between edges in clock cycles, using a counter that starts at the first falling edge. When the fourth transition arrives, the block reports the session type. It also reports an estimate of the bit period in clock cycles, which a later receiver can use. Normal reception stays closed until a measurement succeeds. If the byte takes too long, the block finishes with an error flag set. In every case the block then ignores the line until it gets a new start pulse.

Top module: `serial_mode_sense`

## Requirements
- R1: After reset, `done_o`, `err_o`, `mode_o`, `rx_open_o` and `bit_per_o` are all 0, and nothing is measured until `start_i` is pulsed.
- R2: After a start pulse, a falling edge on the synchronized line is taken as the first edge only once the line has been seen high for at least one clock. A line held low produces no result.
- R3: The first gap is the number of clock cycles from the first edge to the second. The last gap is the number from the third edge to the fourth. If the first gap is less than or equal to the last gap, `mode_o` = 0 (UART). This includes the 0x86 pattern, whose edges fall at 0, 2, 4 and 8 bit times.
- R4: If the first gap is greater than the last gap, `mode_o` = 1 (clocked interface). This includes the 0x30 pattern, whose edges fall at 0, 5, 7 and 9 bit times.
- R5: Let T be the number of cycles from the first edge to the fourth. `bit_per_o` is (T+4)/8 when `mode_o` = 0 and (T+4)/9 when `mode_o` = 1, using integer division.
- R6: `rx_open_o` stays 0 while a byte is being measured. It becomes 1 only together with `done_o` after a successful measurement.
- R7: Once `done_o` is 1, further transitions on `rx_i` change none of the outputs until the next start pulse.
- R8: Suppose the count since the first edge reaches TIMEOUT without a pending edge. Then the block sets `done_o` = 1 and `err_o` = 1, with `mode_o` = 0, `bit_per_o` = 0 and `rx_open_o` = 0.
- R9: A fourth edge that arrives exactly at count TIMEOUT is still accepted as a valid measurement.
- R10: A start pulse after an error clears the outputs and re-arms the block, and a correct byte is then measured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial receive line |
| start_i | input | 1 | One-cycle pulse that arms a new measurement |
| done_o | output | 1 | Result valid (success or error) |
| mode_o | output | 1 | 0 = UART, 1 = clocked I/O interface |
| bit_per_o | output | CNT_W | Estimated bit period in clock cycles |
| err_o | output | 1 | Measurement timed out |
| rx_open_o | output | 1 | Normal reception may proceed |

## Verification
Two things can happen in the same cycle: the timeout can expire just as the fourth edge is detected. The bench provokes this with edge gaps that add up exactly to TIMEOUT, and it expects a valid UART result with the rounded period. It then shifts the last edge one cycle later and expects the error outcome instead. The tie case, where the first and last gaps are equal, is also driven, as is a difference of one cycle in the opposite direction. These pin down the decision boundary between the two modes.

// File: rtl/serial_mode_sense.sv
module serial_mode_sense #(
  parameter int CNT_W   = 16,
  parameter int TIMEOUT = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             start_i,
  output logic             done_o,
  output logic             mode_o,
  output logic [CNT_W-1:0] bit_per_o,
  output logic             err_o,
  output logic             rx_open_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] TO_LIM  = CNT_W'(TIMEOUT);
  localparam logic [CNT_W:0]   RND     = (CNT_W+1)'(4);
  localparam logic [CNT_W:0]   DIV9    = (CNT_W+1)'(9);

  typedef enum logic [2:0] {S_OFF, S_IDLE, S_WB, S_WC, S_WD, S_DONE} st_t;
  st_t st;

  logic rx_m, rx_s, rx_q, seen_hi;
  logic [CNT_W-1:0] cnt, t_ab, t_ac;

  wire edge_x  = rx_s ^ rx_q;
  wire fall_x  = rx_q & ~rx_s;
  wire waiting = (st == S_WB) || (st == S_WC) || (st == S_WD);
  wire expire  = waiting && !edge_x && ((cnt >= TO_LIM) || (cnt == CNT_MAX));
  wire [CNT_W-1:0] t_cd = cnt - t_ac;
  wire io_pick = t_ab > t_cd;
  wire [CNT_W:0] rnd = {1'b0, cnt} + RND;
  wire [CNT_W:0] per = io_pick ? (rnd / DIV9) : (rnd >> 3);

  assign rx_open_o = done_o & ~err_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OFF;
      rx_m <= 1'b1; rx_s <= 1'b1; rx_q <= 1'b1;
      seen_hi <= 1'b0;
      cnt <= '0; t_ab <= '0; t_ac <= '0;
      done_o <= 1'b0; mode_o <= 1'b0; err_o <= 1'b0;
      bit_per_o <= '0;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
      rx_q <= rx_s;
      if (waiting && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (expire) begin
        st <= S_DONE;
        done_o <= 1'b1;
        err_o <= 1'b1;
      end else begin
        case (st)
          S_OFF, S_DONE: if (start_i) begin
            st <= S_IDLE;
            seen_hi <= 1'b0;
            done_o <= 1'b0; err_o <= 1'b0; mode_o <= 1'b0;
            bit_per_o <= '0;
          end
          S_IDLE: begin
            if (rx_s) seen_hi <= 1'b1;
            if (seen_hi && fall_x) begin
              st <= S_WB;
              cnt <= CNT_W'(1);
            end
          end
          S_WB: if (edge_x) begin t_ab <= cnt; st <= S_WC; end
          S_WC: if (edge_x) begin t_ac <= cnt; st <= S_WD; end
          S_WD: if (edge_x) begin
            st <= S_DONE;
            done_o <= 1'b1;
            mode_o <= io_pick;
            bit_per_o <= per[CNT_W-1:0];
          end
          default: st <= S_OFF;
        endcase
      end
    end
  end

  // R8
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (cnt <= TO_LIM));

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && !start_i) |=> (done_o && $stable(mode_o) && $stable(bit_per_o) && $stable(err_o)));

  // R6
  open_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_DONE) |-> !rx_open_o);

  // R2
  idle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !seen_hi) |=> (st == S_IDLE));

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF) |-> (!done_o && !err_o && !rx_open_o));
endmodule

// File: tb/test_serial_mode_sense.sv
module test_serial_mode_sense;
  localparam int CLK_P = 10;
  localparam int CW    = 12;
  localparam int TO    = 300;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, start = 1'b0;
  logic done_o, mode_o, err_o, rx_open_o;
  logic [CW-1:0] bit_per_o;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  serial_mode_sense #(.CNT_W(CW), .TIMEOUT(TO)) i_serial_mode_sense (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .start_i(start),
    .done_o(done_o), .mode_o(mode_o), .bit_per_o(bit_per_o),
    .err_o(err_o), .rx_open_o(rx_open_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic line);
    rx = line; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(int g1, int g2, int g3);
    rx = 1'b0; repeat (g1) @(negedge clk);
    rx = 1'b1; repeat (g2) @(negedge clk);
    rx = 1'b0; repeat (g3) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic wait_done(int lim);
    for (int i = 0; i < lim; i++) begin
      if (done_o) break;
      @(negedge clk);
    end
  endtask

  task automatic measure(string req, int g1, int g2, int g3, int exp_mode, int exp_per);
    pulse_start();
    send(g1, g2, g3);
    wait_done(20);
    check({req, " done"}, done_o, 1);
    check({req, " err"}, err_o, 0);
    check({req, " mode"}, mode_o, exp_mode);
    check({req, " period"}, bit_per_o, exp_per);
    check({req, " open"}, rx_open_o, 1);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    check("R1 done", done_o, 0);
    check("R1 err", err_o, 0);
    check("R1 mode", mode_o, 0);
    check("R1 period", bit_per_o, 0);
    check("R1 open", rx_open_o, 0);
    send(20, 20, 40);
    repeat (20) @(negedge clk);
    check("R1 no start no result", done_o, 0);
  endtask

  task automatic t_patterns();
    measure("R3 uart 0x86 b10", 20, 20, 40, 0, 10);
    measure("R4 io 0x30 b16", 80, 32, 32, 1, 16);
    measure("R4 io 0x30 b20", 100, 40, 40, 1, 20);
    measure("R3 uart 0x86 b30", 60, 60, 120, 0, 30);
  endtask

  task automatic t_rounding();
    measure("R5 round down", 14, 14, 31, 0, 7);
    measure("R5 round up", 14, 14, 33, 0, 8);
  endtask

  task automatic t_boundary();
    measure("R3 tie is uart", 20, 10, 20, 0, 6);
    measure("R4 one more is io", 21, 10, 20, 1, 6);
  endtask

  task automatic t_gate();
    pulse_start();
    rx = 1'b0; repeat (20) @(negedge clk);
    check("R6 closed mid byte", rx_open_o, 0);
    check("R6 not done mid byte", done_o, 0);
    rx = 1'b1; repeat (20) @(negedge clk);
    rx = 1'b0; repeat (40) @(negedge clk);
    rx = 1'b1;
    wait_done(20);
    check("R6 open after", rx_open_o, 1);
  endtask

  task automatic t_ignore();
    measure("R7 first", 20, 20, 40, 0, 10);
    send(80, 32, 32);
    repeat (40) @(negedge clk);
    check("R7 mode kept", mode_o, 0);
    check("R7 period kept", bit_per_o, 10);
    check("R7 done kept", done_o, 1);
  endtask

  task automatic t_idle_high();
    do_reset(1'b0);
    pulse_start();
    repeat (40) @(negedge clk);
    check("R2 low line no result", done_o, 0);
    rx = 1'b1; repeat (5) @(negedge clk);
    send(20, 20, 40);
    wait_done(20);
    check("R2 mode", mode_o, 0);
    check("R2 period", bit_per_o, 10);
  endtask

  task automatic t_timeout();
    measure("R9 edge at limit", 100, 100, 100, 0, 38);
    pulse_start();
    send(100, 100, 101);
    wait_done(20);
    check("R8 late done", done_o, 1);
    check("R8 late err", err_o, 1);
    check("R8 late open", rx_open_o, 0);
    check("R8 late period", bit_per_o, 0);
    pulse_start();
    rx = 1'b0;
    wait_done(TO + 20);
    check("R8 stuck err", err_o, 1);
    check("R8 stuck mode", mode_o, 0);
    rx = 1'b1;
    repeat (5) @(negedge clk);
    measure("R10 after error", 80, 32, 32, 1, 16);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_rounding();
    t_boundary();
    t_gate();
    t_ignore();
    t_idle_high();
    t_timeout();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule